// File: doc/BRIEF.md
# Machine-Mode 64-bit Timer

This block is a 64-bit free-running timer paired with a 64-bit compare value. Together they drive a level timer interrupt. Software reaches the block through a small 32-bit register port. Five registers are mapped there: a control register, the low and high words of the count, and the low and high words of the compare value. Reads are combinational on the address. Writes take effect at the next rising clock edge.

The count can advance on every clock cycle (full-speed mode) or only in cycles where an external tick input is high (tick mode). The pulse on the tick input is produced outside the block. Each of two processor cores has a debug-halt input, and each has its own control bit that makes the timer stand still while that core is halted.

The interrupt stays high for as long as the count is at or above the compare value. Software clears it by moving the compare value ahead of the count. The interrupt goes to an interrupt controller outside this block.

Top module: `mach_timer`

## Requirements
- R1: Register offsets are 0 for control, 1 for count low word, 2 for count high word, 3 for compare low word and 4 for compare high word. Offsets 5 to 7 read as zero. Control bits are enable (bit 0), full speed (bit 1), pause-on-core-0-halt (bit 2) and pause-on-core-1-halt (bit 3). Bits 31:4 read as zero, and control resets to 0xD.
- R2: Both count words reset to zero.
- R3: Both compare words reset to 0xFFFFFFFF.
- R4: With enable set and full speed clear, the count advances by exactly one for each clock cycle in which `tick_in` is high, and holds otherwise.
- R5: With enable and full speed set, the count advances by one on every clock cycle, regardless of `tick_in`.
- R6: With enable clear, the count never changes except through register writes.
- R7: While `dbg_halt[0]` is high and control bit 2 is set, the count holds. Likewise while `dbg_halt[1]` is high and control bit 3 is set. A halt whose pause bit is clear has no effect.
- R8: A write to a count or compare word replaces that 32-bit word only and reads back unchanged.
- R9: A count-word write in a cycle that would also advance the count wins. The written word takes the written value, and the other word keeps its old value in that cycle.
- R10: The count wraps from all ones to zero silently, and a carry out of the low word increments the high word.
- R11: `timer_irq` is high exactly while the 64-bit count is greater than or equal to the 64-bit compare value, compared as unsigned. It follows any change of either value in the same cycle that the value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick_in | input | 1 | Advance pulse used in tick mode |
| dbg_halt | input | 2 | Debug-halt state of core 0 (bit 0) and core 1 (bit 1) |
| timer_irq | output | 1 | Timer interrupt, level |

## Verification
A wrong advance decision shows in the count word that is read on the clock edge right after the cycle at fault, as an off-by-one value. Every counting check therefore reads the count at a known edge count after a control write. A lost carry or a wrong write-versus-advance priority shows up in the other word on that same edge. The bench sets up word boundaries and collisions deliberately to catch these cases. A comparator fault changes `timer_irq` in the same cycle the count crosses the compare value, so the bench samples the interrupt right after each single tick, and includes a compare whose top bit would flip the result under a signed comparison.

// File: rtl/mtm_pkg.sv
// Package: shared register offsets and control-word layout for the
// machine-mode timer. Assumes a 3-bit register offset space.
package mtm_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_CMP_LO = 3'd3,
        SEL_CMP_HI = 3'd4
    } reg_sel_e;

    // Control word, bit 0 first from the LSB.
    typedef struct packed {
        logic pause1;   // bit 3
        logic pause0;   // bit 2
        logic full;     // bit 1
        logic en;       // bit 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam ctrl_t CTRL_RST = '{pause1: 1'b1, pause0: 1'b1, full: 1'b0, en: 1'b1};
endpackage

// File: rtl/mtm_ctrl.sv
// Module: control register and advance decision.
// Holds the control word and works out, each cycle, whether the count
// may step: enable set, advance source active (every cycle or tick), and
// no core halted whose pause bit is set. Assumes dbg_halt is synchronous to clk.
module mtm_ctrl
    import mtm_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic [CTRL_W-1:0]    wdata,
    input  logic                 tick_in,
    input  logic [NUM_CORES-1:0] dbg_halt,
    output ctrl_t                ctrl,
    output logic                 adv
);
    logic [NUM_CORES-1:0] pause_en;
    logic [NUM_CORES-1:0] blocked;
    logic                 source_ok;

    // Control register: reset value, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= CTRL_RST;
        else if (wr_ctrl) ctrl <= ctrl_t'(wdata);
    end

    assign pause_en = {ctrl.pause1, ctrl.pause0};

    // One pause gate per core.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign blocked[c] = pause_en[c] & dbg_halt[c];
    end

    // Advance source: every cycle in full speed, tick pulse otherwise.
    always_comb source_ok = ctrl.full | tick_in;

    // Final advance decision.
    always_comb adv = ctrl.en & source_ok & ~(|blocked);
endmodule

// File: rtl/mtm_split_reg.sv
// Module: wide register split into software-writable words.
// Each word can be loaded on its own. When no word is written, an
// optional increment steps the whole value with carry across words.
// A word write in the same cycle suppresses the increment entirely.
module mtm_split_reg #(
    parameter int                   WORD_W = 32,
    parameter int                   WORDS  = 2,
    parameter logic [WORD_W*WORDS-1:0] RST_VAL = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [WORDS-1:0]        wr,
    input  logic [WORD_W-1:0]       wdata,
    input  logic                    inc,
    output logic [WORD_W*WORDS-1:0] value
);
    localparam int FULL_W = WORD_W * WORDS;

    logic [WORD_W-1:0] word_q [WORDS];
    logic [FULL_W-1:0] stepped;
    logic              step_ok;

    // Incremented value and whether the increment is allowed this cycle.
    always_comb begin
        stepped = value + FULL_W'(1);
        step_ok = inc & ~(|wr);
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Per-word storage: reset, write, or take the stepped slice.
        always_ff @(posedge clk) begin
            if (!rst_n)       word_q[w] <= RST_VAL[w*WORD_W +: WORD_W];
            else if (wr[w])   word_q[w] <= wdata;
            else if (step_ok) word_q[w] <= stepped[w*WORD_W +: WORD_W];
        end
        assign value[w*WORD_W +: WORD_W] = word_q[w];
    end
endmodule

// File: rtl/mtm_cmp.sv
// Module: unsigned greater-or-equal comparator producing the level interrupt.
// Purely combinational, so the interrupt follows register state directly.
module mtm_cmp #(
    parameter int W = 64
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] limit,
    output logic         irq
);
    // Level interrupt while count has reached the limit.
    always_comb irq = (count >= limit);
endmodule

// File: rtl/mach_timer.sv
// Module: machine-mode 64-bit timer with compare interrupt (top).
// Decodes the 32-bit register port, holds control, count and compare
// state, and raises timer_irq while count >= compare. Assumes a single
// write strobe per cycle and synchronous tick and halt inputs.
module mach_timer
    import mtm_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_CORES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 tick_in,
    input  logic [NUM_CORES-1:0] dbg_halt,
    output logic                 timer_irq
);
    localparam int WORDS = 2;
    localparam int CNT_W = DATA_W * WORDS;

    ctrl_t              ctrl;
    logic               adv;
    logic               wr_ctrl;
    logic [WORDS-1:0]   wr_cnt;
    logic [WORDS-1:0]   wr_cmp;
    logic [CNT_W-1:0]   count_q;
    logic [CNT_W-1:0]   cmp_q;

    // Write decode by register offset.
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == SEL_CTRL);
        wr_cnt  = {reg_wr && (reg_addr == SEL_CNT_HI), reg_wr && (reg_addr == SEL_CNT_LO)};
        wr_cmp  = {reg_wr && (reg_addr == SEL_CMP_HI), reg_wr && (reg_addr == SEL_CMP_LO)};
    end

    mtm_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wdata    (reg_wdata[CTRL_W-1:0]),
        .tick_in  (tick_in),
        .dbg_halt (dbg_halt),
        .ctrl     (ctrl),
        .adv      (adv)
    );

    mtm_split_reg #(.WORD_W(DATA_W), .WORDS(WORDS), .RST_VAL('0)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_cnt),
        .wdata (reg_wdata),
        .inc   (adv),
        .value (count_q)
    );

    mtm_split_reg #(.WORD_W(DATA_W), .WORDS(WORDS), .RST_VAL('1)) u_limit (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_cmp),
        .wdata (reg_wdata),
        .inc   (1'b0),
        .value (cmp_q)
    );

    mtm_cmp #(.W(CNT_W)) u_cmp (
        .count (count_q),
        .limit (cmp_q),
        .irq   (timer_irq)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        case (reg_addr)
            SEL_CTRL:   reg_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            SEL_CNT_LO: reg_rdata = count_q[DATA_W-1:0];
            SEL_CNT_HI: reg_rdata = count_q[CNT_W-1:DATA_W];
            SEL_CMP_LO: reg_rdata = cmp_q[DATA_W-1:0];
            SEL_CMP_HI: reg_rdata = cmp_q[CNT_W-1:DATA_W];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mtm_checker.sv
// Module: property checker for mach_timer, attached by bind.
// Watches the register port, debug inputs and internal count/control state.
module mtm_checker #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [2:0]          reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [1:0]          dbg_halt,
    input logic [3:0]          ctrl_bits,
    input logic                adv,
    input logic [2*DATA_W-1:0] count,
    input logic [2*DATA_W-1:0] limit
);
    logic cnt_wr;
    assign cnt_wr = reg_wr && (reg_addr == 3'd1 || reg_addr == 3'd2);

    assert_ctrl_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ctrl_bits == 4'hD);

    assert_count_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> count == '0);

    assert_limit_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> limit == '1);

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cnt_wr) |=> count == $past(count) + 1'b1);

    assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !cnt_wr) |=> $stable(count));

    assert_pause_core0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt[0] && ctrl_bits[2] && !cnt_wr) |=> $stable(count));

    assert_pause_core1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt[1] && ctrl_bits[3] && !cnt_wr) |=> $stable(count));

    assert_low_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=>
            (count[DATA_W-1:0] == $past(reg_wdata)) &&
            (count[2*DATA_W-1:DATA_W] == $past(count[2*DATA_W-1:DATA_W])));

    assert_high_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd2) |=>
            (count[2*DATA_W-1:DATA_W] == $past(reg_wdata)) &&
            (count[DATA_W-1:0] == $past(count[DATA_W-1:0])));
endmodule

bind mach_timer mtm_checker #(.DATA_W(DATA_W)) u_mtm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dbg_halt  (dbg_halt),
    .ctrl_bits (ctrl),
    .adv       (adv),
    .count     (count_q),
    .limit     (cmp_q)
);

// File: tb/mach_timer_test.sv
`timescale 1ns/1ps
// Directed bench for mach_timer: one task per scenario, each self-checking.
// Inputs change on falling edges; outputs are sampled shortly after.
module mach_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick_in = 1'b0;
    logic [1:0]  dbg_halt = 2'b00;
    logic        timer_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mach_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_in   (tick_in),
        .dbg_halt  (dbg_halt),
        .timer_irq (timer_irq)
    );

    // All tasks start and end on a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
    endtask

    task automatic chk_reg(input logic [2:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #0.2;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: offset %0d read 0x%08h expected 0x%08h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        #0.2;
        checks++;
        if (timer_irq !== exp) begin
            errors++;
            $display("FAIL %s: timer_irq %0b expected %0b", req, timer_irq, exp);
        end
    endtask

    task automatic load_count(input logic [31:0] hi, input logic [31:0] lo);
        wr(3'd1, lo);
        wr(3'd2, hi);
    endtask

    task automatic t_reset();
        chk_reg(3'd0, 32'h0000_000D, "R1");
        chk_reg(3'd7, 32'h0, "R1");
        chk_reg(3'd1, 32'h0, "R2");
        chk_reg(3'd2, 32'h0, "R2");
        chk_reg(3'd3, 32'hFFFF_FFFF, "R3");
        chk_reg(3'd4, 32'hFFFF_FFFF, "R3");
        chk_irq(1'b0, "R11");
    endtask

    task automatic t_tick_mode();
        // Reset control: enable, tick mode. No tick -> hold.
        repeat (3) @(negedge clk);
        chk_reg(3'd1, 32'd0, "R4");
        for (int i = 0; i < 5; i++) begin
            pulse_tick();
            @(negedge clk);
        end
        chk_reg(3'd1, 32'd5, "R4");
    endtask

    task automatic t_disabled();
        wr(3'd0, 32'h0);
        for (int i = 0; i < 4; i++) pulse_tick();
        chk_reg(3'd1, 32'd5, "R6");
        chk_reg(3'd0, 32'h0, "R1");
    endtask

    task automatic t_full_speed();
        load_count(32'h0, 32'h0);
        wr(3'd0, 32'h3);
        repeat (9) @(negedge clk);
        wr(3'd0, 32'h0);    // this edge still advances
        chk_reg(3'd1, 32'd10, "R5");
        chk_reg(3'd2, 32'd0, "R5");
    endtask

    task automatic t_pause();
        load_count(32'h0, 32'h0);
        dbg_halt = 2'b01;
        wr(3'd0, 32'h7);    // enable, full, pause on core 0
        chk_reg(3'd1, 32'd0, "R7");
        repeat (5) @(negedge clk);
        chk_reg(3'd1, 32'd0, "R7");
        dbg_halt = 2'b10;   // core 1 halted, its pause off
        repeat (4) @(negedge clk);
        chk_reg(3'd1, 32'd4, "R7");
        wr(3'd0, 32'hB);    // enable, full, pause on core 1
        chk_reg(3'd1, 32'd5, "R7");
        repeat (3) @(negedge clk);
        chk_reg(3'd1, 32'd5, "R7");
        dbg_halt = 2'b01;
        repeat (2) @(negedge clk);
        wr(3'd0, 32'h0);
        chk_reg(3'd1, 32'd8, "R7");
        dbg_halt = 2'b00;
    endtask

    task automatic t_word_write();
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h1234_5678);
        wr(3'd1, 32'h9ABC_DEF0);
        wr(3'd3, 32'h0BAD_F00D);
        wr(3'd4, 32'hC0DE_0001);
        chk_reg(3'd1, 32'h9ABC_DEF0, "R8");
        chk_reg(3'd2, 32'h1234_5678, "R8");
        chk_reg(3'd3, 32'h0BAD_F00D, "R8");
        chk_reg(3'd4, 32'hC0DE_0001, "R8");
    endtask

    task automatic t_write_wins();
        load_count(32'd5, 32'h0);
        wr(3'd0, 32'h3);
        wr(3'd1, 32'h100);
        chk_reg(3'd1, 32'h100, "R9");
        @(negedge clk);
        chk_reg(3'd1, 32'h101, "R9");
        wr(3'd0, 32'h0);
        chk_reg(3'd1, 32'h102, "R9");
        chk_reg(3'd2, 32'd5, "R9");
        // High-word write at the moment the low word would carry.
        load_count(32'd5, 32'hFFFF_FFFF);
        wr(3'd0, 32'h3);
        wr(3'd2, 32'd7);
        chk_reg(3'd1, 32'hFFFF_FFFF, "R9");
        chk_reg(3'd2, 32'd7, "R9");
        wr(3'd0, 32'h0);
        chk_reg(3'd1, 32'h0, "R10");
        chk_reg(3'd2, 32'd8, "R10");
    endtask

    task automatic t_wrap();
        load_count(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        wr(3'd0, 32'h1);
        pulse_tick();
        chk_reg(3'd1, 32'h0, "R10");
        chk_reg(3'd2, 32'h0, "R10");
        load_count(32'h0, 32'hFFFF_FFFF);
        pulse_tick();
        chk_reg(3'd1, 32'h0, "R10");
        chk_reg(3'd2, 32'h1, "R10");
        wr(3'd0, 32'h0);
    endtask

    task automatic t_irq();
        wr(3'd4, 32'h0);
        wr(3'd3, 32'd10);
        load_count(32'h0, 32'd9);
        wr(3'd0, 32'h1);
        chk_irq(1'b0, "R11");
        pulse_tick();
        chk_irq(1'b1, "R11");   // equal
        pulse_tick();
        chk_irq(1'b1, "R11");   // above
        wr(3'd3, 32'd20);
        chk_irq(1'b0, "R11");   // compare moved ahead
        wr(3'd0, 32'h0);
        load_count(32'h8000_0000, 32'h0);
        wr(3'd4, 32'h1);
        wr(3'd3, 32'h0);
        chk_irq(1'b1, "R11");   // unsigned: top bit set is large
        wr(3'd4, 32'h8000_0001);
        chk_irq(1'b0, "R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tick_mode();
        t_disabled();
        t_full_speed();
        t_pause();
        t_word_write();
        t_write_wins();
        t_wrap();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule